// File: doc/BRIEF.md
# Byte-Addressed Seconds Counter

This block keeps a 32-bit count of seconds and exposes it through a byte-wide register window. A strobe from an external prescaler advances the count by one while the run bit of the control register is set. Software presets the time by writing four byte registers. Each write lands on its slice of the live counter in the cycle it is issued, so the counter never stops while a preset is in progress. Software reads the count back through four byte read registers.

Because each byte is loaded into a running counter, a carry out of the low byte can reach the upper bytes partway through a preset. Driver code avoids this with a fixed order: zero byte 0, write bytes 1 to 3, then write byte 0 last. On readback, software reads the low byte a second time. If that second value is smaller than the first, a carry has occurred and all four bytes must be read again. A fixed identifier register lets software confirm which kind of block sits at the address.

Top module: `secs_ctr_periph`

## Requirements
- R1: After synchronous reset the count is 0, the control register reads 0x80, and `rd_data` is 0x00.
- R2: While control bit 7 is 1, every clock edge with `tick` high and no write to a count byte adds one to the count. A carry moves from each byte into the next byte up.
- R3: While control bit 7 is 0, `tick` has no effect and the count holds its value.
- R4: An increment from 0xFFFFFFFF gives 0x00000000.
- R5: A write to offset 0x40+i (i = 0..3, byte 0 the least significant) replaces byte i of the live count at that clock edge. The other bytes are left unchanged.
- R6: If a count-byte write and an enabled tick fall in the same cycle, the written byte takes the written value. Every byte above it still receives the carry worked out from the count as it stood before that edge.
- R7: A read of offset 0x48+i returns byte i of the count. `rd_data` is registered and shows the value of the offset presented before a clock edge from that edge onward.
- R8: Offset 0x05 reads the fixed identifier 0x01.
- R9: Every offset other than 0x05, 0x46 and 0x48..0x4B reads 0x00. This includes the write-only count offsets 0x40..0x43. A write to any offset other than 0x40..0x43 and 0x46 changes neither the count nor the control register.
- R10: Offset 0x46 is an 8-bit control register that reads back the last value written to it. Only bit 7 (the run bit) affects counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe that advances the count, once per second |
| addr | input | 8 | Register offset for read and write |
| wr_en | input | 1 | Write strobe for `addr` |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data for the offset presented on the previous edge |

## Verification
Writes and ticks act on the count at the clock edge where they are presented. A read returns that count at the following edge, because `rd_data` is one register stage behind `addr`. The bench therefore drives every input on the falling edge. It samples `rd_data` just after the rising edge that captured the read offset, and it issues each readback one full cycle after the write or tick it checks. Ticks are held low during readback, so all four bytes come from the same count value. The R6 case places a tick and a byte write on the same falling edge, so both act at one rising edge.

// File: rtl/secs_ctr_pkg.sv
package secs_ctr_pkg;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam int NBYTES = 4;

  localparam logic [7:0] OFS_IDENT   = 8'h05;
  localparam logic [7:0] OFS_WR_BASE = 8'h40;
  localparam logic [7:0] OFS_CTRL    = 8'h46;
  localparam logic [7:0] OFS_RD_BASE = 8'h48;

  localparam logic [7:0] IDENT_VALUE = 8'h01;
  localparam logic [7:0] CTRL_RESET  = 8'h80;
  localparam int         RUN_BIT     = 7;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_IDENT = 2'd1,
    SRC_CTRL  = 2'd2,
    SRC_COUNT = 2'd3
  } rd_src_e;
endpackage

// File: rtl/secs_ctr_decode.sv
module secs_ctr_decode
  import secs_ctr_pkg::*;
#(
  parameter int N_BYTES = NBYTES,
  parameter int A_W     = AW,
  localparam int IDX_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic [A_W-1:0]     addr,
  input  logic               wr_en,
  output logic [N_BYTES-1:0] byte_we,
  output logic               ctrl_we,
  output rd_src_e            rd_src,
  output logic [IDX_W-1:0]   rd_idx
);
  for (genvar i = 0; i < N_BYTES; i++) begin : g_wsel
    assign byte_we[i] = wr_en && (addr == A_W'(int'(OFS_WR_BASE) + i));
  end

  assign ctrl_we = wr_en && (addr == A_W'(OFS_CTRL));

  always_comb begin
    rd_src = SRC_ZERO;
    rd_idx = '0;
    if (addr == A_W'(OFS_IDENT)) rd_src = SRC_IDENT;
    if (addr == A_W'(OFS_CTRL))  rd_src = SRC_CTRL;
    for (int i = 0; i < N_BYTES; i++) begin
      if (addr == A_W'(int'(OFS_RD_BASE) + i)) begin
        rd_src = SRC_COUNT;
        rd_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/secs_ctr_core.sv
module secs_ctr_core
  import secs_ctr_pkg::*;
#(
  parameter int N_BYTES = NBYTES,
  localparam int CW     = N_BYTES * DW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic [N_BYTES-1:0] byte_we,
  input  logic [DW-1:0]      wr_data,
  output logic [CW-1:0]      count
);
  // cy[i] is the carry into byte i, derived from pre-edge values only,
  // so a byte written this cycle still passes its old carry upward.
  logic [N_BYTES:0] cy;
  assign cy[0] = inc;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    logic [DW-1:0] q;

    always_ff @(posedge clk) begin
      if (rst)             q <= '0;
      else if (byte_we[i]) q <= wr_data;
      else if (cy[i])      q <= q + 1'b1;
    end

    assign cy[i+1]           = cy[i] & (&q);
    assign count[i*DW +: DW] = q;
  end
endmodule

// File: rtl/secs_ctr_rdport.sv
module secs_ctr_rdport
  import secs_ctr_pkg::*;
#(
  parameter int N_BYTES = NBYTES,
  localparam int IDX_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1,
  localparam int CW     = N_BYTES * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  rd_src_e          rd_src,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [CW-1:0]    count,
  input  logic [DW-1:0]    ctrl,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] sel_byte;
  logic [DW-1:0] nxt;

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < N_BYTES; i++) begin
      if (rd_idx == IDX_W'(i)) sel_byte = count[i*DW +: DW];
    end
  end

  always_comb begin
    unique case (rd_src)
      SRC_IDENT: nxt = IDENT_VALUE;
      SRC_CTRL:  nxt = ctrl;
      SRC_COUNT: nxt = sel_byte;
      default:   nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= nxt;
  end
endmodule

// File: rtl/secs_ctr_periph.sv
module secs_ctr_periph
  import secs_ctr_pkg::*;
#(
  parameter int N_BYTES = NBYTES,
  parameter int A_W     = AW,
  localparam int IDX_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1,
  localparam int CW     = N_BYTES * DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [A_W-1:0] addr,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data
);
  logic [N_BYTES-1:0] byte_we;
  logic               ctrl_we;
  rd_src_e            rd_src;
  logic [IDX_W-1:0]   rd_idx;
  logic [DW-1:0]      ctrl_q;
  logic [CW-1:0]      count_q;
  logic               inc;

  secs_ctr_decode #(.N_BYTES(N_BYTES), .A_W(A_W)) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .byte_we (byte_we),
    .ctrl_we (ctrl_we),
    .rd_src  (rd_src),
    .rd_idx  (rd_idx)
  );

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= CTRL_RESET;
    else if (ctrl_we) ctrl_q <= wr_data;
  end

  assign inc = tick & ctrl_q[RUN_BIT];

  secs_ctr_core #(.N_BYTES(N_BYTES)) u_core (
    .clk     (clk),
    .rst     (rst),
    .inc     (inc),
    .byte_we (byte_we),
    .wr_data (wr_data),
    .count   (count_q)
  );

  secs_ctr_rdport #(.N_BYTES(N_BYTES)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_src  (rd_src),
    .rd_idx  (rd_idx),
    .count   (count_q),
    .ctrl    (ctrl_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/secs_ctr_chk.sv
module secs_ctr_chk
  import secs_ctr_pkg::*;
#(
  parameter int N_BYTES = NBYTES,
  parameter int A_W     = AW,
  localparam int CW     = N_BYTES * DW
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic [A_W-1:0] addr,
  input logic           wr_en,
  input logic [DW-1:0]  wr_data,
  input logic [DW-1:0]  rd_data,
  input logic [CW-1:0]  count,
  input logic [DW-1:0]  ctrl
);
  logic cnt_wr;
  logic decoded;
  assign cnt_wr  = wr_en && (addr >= A_W'(OFS_WR_BASE)) &&
                   (addr <  A_W'(int'(OFS_WR_BASE) + N_BYTES));
  assign decoded = (addr == A_W'(OFS_IDENT)) || (addr == A_W'(OFS_CTRL)) ||
                   ((addr >= A_W'(OFS_RD_BASE)) &&
                    (addr <  A_W'(int'(OFS_RD_BASE) + N_BYTES)));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && ctrl[RUN_BIT] && !cnt_wr) |=> (count == CW'($past(count) + 1'b1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[RUN_BIT] && !cnt_wr) |=> $stable(count));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && ctrl[RUN_BIT] && !cnt_wr && (&count)) |=> (count == '0));

  p_low_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_W'(OFS_WR_BASE)) |=> (count[DW-1:0] == $past(wr_data)));

  p_ident_r8: assert property (@(posedge clk) disable iff (rst)
    (addr == A_W'(OFS_IDENT)) |=> (rd_data == IDENT_VALUE));

  p_undecoded_r9: assert property (@(posedge clk) disable iff (rst)
    !decoded |=> (rd_data == '0));

  p_ctrl_wr_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_W'(OFS_CTRL)) |=> (ctrl == $past(wr_data)));
endmodule

bind secs_ctr_periph secs_ctr_chk #(.N_BYTES(N_BYTES), .A_W(A_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .addr    (addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .count   (count_q),
  .ctrl    (ctrl_q)
);

// File: tb/tb_secs_ctr_periph.sv
module tb_secs_ctr_periph;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] addr = 8'hFF;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  secs_ctr_periph dut (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'hFF;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(posedge clk);
    #1 d = rd_data;
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(8'h48 + 8'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic preset(logic [31:0] v);
    wr(8'h40, 8'h00);
    wr(8'h41, v[15:8]);
    wr(8'h42, v[23:16]);
    wr(8'h43, v[31:24]);
    wr(8'h40, v[7:0]);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] b;
    logic [31:0] v;
    chk("R1 rd_data after reset", 32'(rd_data), 32'h0);
    rd(8'h46, b);
    chk("R1 ctrl reset value", 32'(b), 32'h80);
    rd32(v);
    chk("R1 count reset value", v, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(8'h46, 8'h00);
    preset(32'h1234_56FE);
    wr(8'h46, 8'h80);
    for (int k = 0; k < 3; k++) pulse_tick();
    rd32(v);
    chk("R2 three ticks with carry", v, 32'h1234_5701);
    @(negedge clk); tick = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b0;
    rd32(v);
    chk("R2 back-to-back ticks", v, 32'h1234_5705);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    wr(8'h46, 8'h00);
    preset(32'h0BAD_F00D);
    for (int k = 0; k < 5; k++) pulse_tick();
    rd32(v);
    chk("R3 ticks ignored while stopped", v, 32'h0BAD_F00D);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(8'h46, 8'h00);
    preset(32'hFFFF_FFFF);
    wr(8'h46, 8'h80);
    pulse_tick();
    rd32(v);
    chk("R4 wrap to zero", v, 32'h0);
  endtask

  task automatic t_byte_write();
    logic [31:0] v;
    wr(8'h46, 8'h00);
    preset(32'h1122_3344);
    rd32(v);
    chk("R7 readback of preset", v, 32'h1122_3344);
    wr(8'h42, 8'hAB);
    rd32(v);
    chk("R5 single byte replace", v, 32'h11AB_3344);
    wr(8'h43, 8'h00);
    rd32(v);
    chk("R5 top byte replace", v, 32'h00AB_3344);
  endtask

  task automatic t_write_vs_tick();
    logic [31:0] v;
    wr(8'h46, 8'h00);
    preset(32'h0000_01FF);
    wr(8'h46, 8'h80);
    @(negedge clk);
    tick = 1'b1; addr = 8'h40; wr_en = 1'b1; wr_data = 8'h10;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; addr = 8'hFF;
    rd32(v);
    chk("R6 low byte written, carry kept", v, 32'h0000_0210);
    wr(8'h46, 8'h00);
    preset(32'h0000_FFFF);
    wr(8'h46, 8'h80);
    @(negedge clk);
    tick = 1'b1; addr = 8'h41; wr_en = 1'b1; wr_data = 8'h77;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; addr = 8'hFF;
    rd32(v);
    chk("R6 middle byte written, carry passes", v, 32'h0001_7700);
  endtask

  task automatic t_ident_ctrl();
    logic [7:0] b;
    rd(8'h05, b);
    chk("R8 identifier", 32'(b), 32'h01);
    wr(8'h46, 8'h3C);
    rd(8'h46, b);
    chk("R10 ctrl readback", 32'(b), 32'h3C);
  endtask

  task automatic t_undecoded();
    logic [31:0] v;
    logic [7:0] b;
    wr(8'h46, 8'h00);
    preset(32'hCAFE_F00D);
    wr(8'h44, 8'h5A);
    wr(8'h4C, 8'hA5);
    wr(8'h05, 8'h33);
    rd32(v);
    chk("R9 count untouched by stray writes", v, 32'hCAFE_F00D);
    rd(8'h46, b);
    chk("R9 ctrl untouched by stray writes", 32'(b), 32'h00);
    rd(8'h05, b);
    chk("R9 identifier not writable", 32'(b), 32'h01);
    rd(8'h44, b);
    chk("R9 undecoded reads zero", 32'(b), 32'h00);
    rd(8'h40, b);
    chk("R9 write-only byte reads zero", 32'(b), 32'h00);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_hold();
    t_wrap();
    t_byte_write();
    t_write_vs_tick();
    t_ident_ctrl();
    t_undecoded();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule